// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a two-port shared memory and turns accesses to two reserved words into a doorbell between the ports. It observes each port's address, select, write strobe and read strobe. It keeps one pending flag for each port and presents that flag as an active-low interrupt output.

The topmost address (all ones) is the mailbox of port 1. The address one below it is the mailbox of port 0. When a port writes its partner's mailbox, the partner's interrupt is raised. When the owner later reads its own mailbox, its interrupt is released. With a 16-bit address the two words are FFFF (port 1) and FFFE (port 0). With a 17-bit address they are 1FFFF and 1FFFE.

The block tracks only the interrupt state. The storage array, collision handling and any locking scheme are outside it. All state updates on the rising clock edge. Reset is asynchronous and active low.

Top module: `mbx_irq`

## Requirements
- R1: While reset is active, and afterwards until an access sets a flag, both `p0_irq_n` and `p1_irq_n` read 1 (deasserted).
- R2: A port 0 access with sel=1, wr=1 at address all-ones drives `p1_irq_n` to 0 one clock after the access.
- R3: A port 1 access with sel=1, wr=1 at address all-ones minus one drives `p0_irq_n` to 0 one clock after the access.
- R4: A port 1 access with sel=1, rd=1, wr=0 at address all-ones returns `p1_irq_n` to 1 one clock after the access, unless R7 applies.
- R5: A port 0 access with sel=1, rd=1, wr=0 at address all-ones minus one returns `p0_irq_n` to 1 one clock after the access, unless R7 applies.
- R6: A port that writes its own mailbox leaves both interrupt outputs unchanged.
- R7: If one port sets a flag and the owning port clears the same flag in the same cycle, the flag ends up set (output 0).
- R8: Accesses with sel=0, and accesses to any address other than the two mailboxes, leave both interrupt outputs unchanged.
- R9: Reading the partner's mailbox leaves both interrupt outputs unchanged.
- R10: An access with sel=1 and both wr=1 and rd=1 acts as a write only.
- R11: With no strobe active on either port, both interrupt outputs keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_addr | input | AW | Port 0 address |
| p0_sel | input | 1 | Port 0 access enable, active high |
| p0_wr | input | 1 | Port 0 write strobe |
| p0_rd | input | 1 | Port 0 read strobe |
| p1_addr | input | AW | Port 1 address |
| p1_sel | input | 1 | Port 1 access enable, active high |
| p1_wr | input | 1 | Port 1 write strobe |
| p1_rd | input | 1 | Port 1 read strobe |
| p0_irq_n | output | 1 | Port 0 interrupt, active low |
| p1_irq_n | output | 1 | Port 1 interrupt, active low |

## Verification
Every set or clear is due exactly one rising edge after the access that causes it, because the flag register is the only stage between the strobes and the outputs. The bench drives each access at a falling edge, lets one rising edge pass, and compares both outputs at the next falling edge. Only then does it return the inputs to idle. For every vector, the expected state of both flags is derived from a small arithmetic model of the two mailbox addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Port identifiers; port 1 owns the topmost word.
  typedef enum logic {
    PORT_0 = 1'b0,
    PORT_1 = 1'b1
  } port_id_e;

  // Mailbox word owned by a port, for an address of aw bits (aw <= 32).
  function automatic logic [31:0] box_addr(input int aw, input logic owner);
    logic [31:0] top;
    top = 32'hFFFF_FFFF >> (32 - aw);
    return owner ? top : (top - 32'd1);
  endfunction

  // Write has precedence over read on a single port.
  function automatic logic eff_write(input logic sel, input logic wr);
    return sel & wr;
  endfunction

  function automatic logic eff_read(input logic sel, input logic wr, input logic rd);
    return sel & rd & ~wr;
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int   AW    = 16,
  parameter logic OWNER = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic          sel,
  input  logic          wr,
  input  logic          rd,
  output logic          post_peer,
  output logic          fetch_own
);
  import mbx_pkg::*;

  localparam logic [AW-1:0] OWN_BOX  = AW'(box_addr(AW, OWNER));
  localparam logic [AW-1:0] PEER_BOX = AW'(box_addr(AW, ~OWNER));

  logic hit_own;
  logic hit_peer;

  assign hit_own   = (addr == OWN_BOX);
  assign hit_peer  = (addr == PEER_BOX);
  assign post_peer = eff_write(sel, wr) & hit_peer;
  assign fetch_own = eff_read(sel, wr, rd) & hit_own;

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pending <= 1'b0;
    else if (set) pending <= 1'b1;
    else if (clr) pending <= 1'b0;
  end

  assign irq_n = ~pending;

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] p0_addr,
  input  logic          p0_sel,
  input  logic          p0_wr,
  input  logic          p0_rd,
  input  logic [AW-1:0] p1_addr,
  input  logic          p1_sel,
  input  logic          p1_wr,
  input  logic          p1_rd,
  output logic          p0_irq_n,
  output logic          p1_irq_n
);
  localparam int NPORT = 2;

  logic [AW-1:0]    addr_v [NPORT];
  logic [NPORT-1:0] sel_v, wr_v, rd_v;
  logic [NPORT-1:0] post;     // port k wrote its partner's word
  logic [NPORT-1:0] fetch;    // port k read its own word
  logic [NPORT-1:0] set_evt;  // flag k is being raised
  logic [NPORT-1:0] clr_evt;  // flag k is being released
  logic [NPORT-1:0] irq_n_v;

  assign addr_v[0] = p0_addr;
  assign addr_v[1] = p1_addr;
  assign sel_v     = {p1_sel, p0_sel};
  assign wr_v      = {p1_wr,  p0_wr};
  assign rd_v      = {p1_rd,  p0_rd};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    mbx_decode #(
      .AW   (AW),
      .OWNER(1'(g))
    ) u_dec (
      .addr     (addr_v[g]),
      .sel      (sel_v[g]),
      .wr       (wr_v[g]),
      .rd       (rd_v[g]),
      .post_peer(post[g]),
      .fetch_own(fetch[g])
    );

    assign set_evt[g] = post[NPORT-1-g];
    assign clr_evt[g] = fetch[g];

    mbx_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set_evt[g]),
      .clr  (clr_evt[g]),
      .irq_n(irq_n_v[g])
    );
  end

  assign p0_irq_n = irq_n_v[0];
  assign p1_irq_n = irq_n_v[1];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] set_evt,
  input logic [1:0] clr_evt,
  input logic [1:0] irq_n,
  input logic       sel_any
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_n == 2'b11));

  p_raise_p1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[1] |=> !irq_n[1]);

  p_raise_p0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[0] |=> !irq_n[0]);

  p_release_p1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt[1] && !set_evt[1]) |=> irq_n[1]);

  p_release_p0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt[0] && !set_evt[0]) |=> irq_n[0]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_evt & clr_evt)) |=> ((irq_n & set_evt & clr_evt) == 2'b00));

  p_no_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_any |=> $stable(irq_n));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt == 2'b00 && clr_evt == 2'b00) |=> $stable(irq_n));

endmodule

bind mbx_irq mbx_irq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .set_evt(set_evt),
  .clr_evt(clr_evt),
  .irq_n  ({p1_irq_n, p0_irq_n}),
  .sel_any(p0_sel | p1_sel)
);

// File: tb/mbx_irq_tb.sv
module mbx_irq_tb;
  localparam int AW         = 4;
  localparam int CLK_PERIOD = 10;
  localparam int TOP_WORD   = (1 << AW) - 1;  // port 1 word
  localparam int NEXT_WORD  = (1 << AW) - 2;  // port 0 word

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] a0, a1;
  logic          s0, w0, r0, s1, w1, r1;
  logic          p0_irq_n, p1_irq_n;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  exp0 = 1'b0;  // expected pending flag, port 0
  bit  exp1 = 1'b0;  // expected pending flag, port 1
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .p0_addr(a0), .p0_sel(s0), .p0_wr(w0), .p0_rd(r0),
    .p1_addr(a1), .p1_sel(s1), .p1_wr(w1), .p1_rd(r1),
    .p0_irq_n(p0_irq_n), .p1_irq_n(p1_irq_n)
  );

  task automatic check(input string tag);
    n_vec++;
    if (p0_irq_n !== !exp0 || p1_irq_n !== !exp1) begin
      n_bad++;
      $display("FAIL %s: irq_n p0=%b p1=%b expected p0=%b p1=%b",
               tag, p0_irq_n, p1_irq_n, !exp0, !exp1);
    end
  endtask

  task automatic idle();
    a0 = '0; a1 = '0;
    {s0, w0, r0, s1, w1, r1} = '0;
  endtask

  // Drive one cycle of accesses, update the model, check after the edge.
  task automatic drive(input int pa0, input bit ps0, input bit pw0, input bit pr0,
                       input int pa1, input bit ps1, input bit pw1, input bit pr1,
                       input string tag);
    bit up0, dn0, up1, dn1;
    @(negedge clk);
    a0 = AW'(pa0); s0 = ps0; w0 = pw0; r0 = pr0;
    a1 = AW'(pa1); s1 = ps1; w1 = pw1; r1 = pr1;
    up1 = ps0 && pw0 && pa0 == TOP_WORD;
    dn0 = ps0 && pr0 && !pw0 && pa0 == NEXT_WORD;
    up0 = ps1 && pw1 && pa1 == NEXT_WORD;
    dn1 = ps1 && pr1 && !pw1 && pa1 == TOP_WORD;
    exp0 = up0 ? 1'b1 : (dn0 ? 1'b0 : exp0);
    exp1 = up1 ? 1'b1 : (dn1 ? 1'b0 : exp1);
    @(negedge clk);
    check(tag);
    idle();
  endtask

  function automatic string tag_of(input int p, input int ad, input bit sl,
                                   input bit wr, input bit rd);
    int peer = (p == 0) ? TOP_WORD : NEXT_WORD;
    int own  = (p == 0) ? NEXT_WORD : TOP_WORD;
    if (!sl)                                   return "R8";
    if (wr && rd && (ad == peer || ad == own)) return "R10";
    if (wr && ad == peer)                      return (p == 0) ? "R2" : "R3";
    if (wr && ad == own)                       return "R6";
    if (rd && ad == own)                       return (p == 1) ? "R4" : "R5";
    if (rd && ad == peer)                      return "R9";
    if (!wr && !rd)                            return "R11";
    return "R8";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // Sweep: every start state x port x address x strobe pattern.
    for (int st = 0; st < 4; st++) begin
      for (int p = 0; p < 2; p++) begin
        for (int ad = 0; ad < (1 << AW); ad++) begin
          for (int op = 0; op < 8; op++) begin
            bit sl = op[2], wr = op[1], rd = op[0];
            drive(NEXT_WORD, 1, 0, 1, TOP_WORD, 1, 0, 1, "setup R4 R5");
            drive(TOP_WORD, st[1], 1, 0, NEXT_WORD, st[0], 1, 0, "setup R2 R3");
            if (p == 0) drive(ad, sl, wr, rd, 0, 0, 0, 0, tag_of(0, ad, sl, wr, rd));
            else        drive(0, 0, 0, 0, ad, sl, wr, rd, tag_of(1, ad, sl, wr, rd));
          end
        end
      end
    end

    // R7: set and clear of the same flag in one cycle, from each start value.
    for (int st = 0; st < 2; st++) begin
      drive(NEXT_WORD, 1, 0, 1, TOP_WORD, 1, 0, 1, "setup R4 R5");
      if (st == 1) drive(TOP_WORD, 1, 1, 0, NEXT_WORD, 1, 1, 0, "setup R2 R3");
      drive(NEXT_WORD, 1, 0, 1, NEXT_WORD, 1, 1, 0, "R7 port0 flag");
      drive(TOP_WORD, 1, 1, 0, TOP_WORD, 1, 0, 1, "R7 port1 flag");
    end

    // Both ports ring each other at once, then both release at once.
    drive(NEXT_WORD, 1, 0, 1, TOP_WORD, 1, 0, 1, "R4 R5 joint clear");
    drive(TOP_WORD, 1, 1, 0, NEXT_WORD, 1, 1, 0, "R2 R3 joint set");
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R11 hold");
    drive(NEXT_WORD, 1, 0, 1, TOP_WORD, 1, 0, 1, "R4 R5 joint clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule